// File: doc/BRIEF.md
# Temporal Belt Operand Store

This block keeps the most recent results of a datapath in a short, fixed-length belt. An operation never names where its result goes. Each result simply lands at the front of the belt as position 0, everything already there gets one position older, and once the belt is full the oldest item is lost. Consumers fetch operands by giving a position counted back from the newest item, so the operand number is an age and not a register name. Each result travels with a small metadata word: a not-a-result (NaR) flag, an operand width code and a lane count. Because this word is stored with the item, the instruction that uses an operand does not have to encode its width.

Items are never copied from one storage slot to another. Each call frame owns a ring of slots and a head pointer. When the head pointer advances, every stored item takes a new position name while its data stays in place. A frame counter picks the active ring. A call raises the counter and clears the new ring, so the callee starts with an empty belt. A return lowers the counter, and the caller's items come back exactly as they were left. A stall input freezes the whole belt while a neighbouring store is out of step with it.

Top module: `belt_store`

## Requirements
- R1: A single result offered on either drop port while not stalled becomes position 0 after the next rising clock edge. Every item already in the active frame moves one position older.
- R2: When both drop ports carry a result in the same cycle, the result on drop port 0 becomes position 0 and the result on drop port 1 becomes position 1.
- R3: A frame holds at most LEN (8) items. `fill_o` saturates at LEN, and an item is discarded once it would move past position LEN-1.
- R4: A read at a position greater than or equal to `fill_o` returns `rd_nar_o`=1, with data 0, width code 0 and lane field 0.
- R5: A read of a held item returns the data, NaR flag, 2-bit width code and lane field that were dropped with that item, unchanged.
- R6: A call (`call_i`=1, `ret_i`=0) raises `frame_o` by one, and the new frame shows `fill_o`=0. A call made while `frame_o`=FRAMES-1 (3) is ignored.
- R7: A return (`ret_i`=1, `call_i`=0) lowers `frame_o` by one, and the caller's items reappear at their old positions. A return made while `frame_o`=0 is ignored.
- R8: When `call_i` and `ret_i` are both high in the same cycle, the frame does not change.
- R9: Results dropped in the same cycle as a call or a return go into the frame that was active before that clock edge.
- R10: While `stall_i`=1, drops, calls and returns are all ignored, and the belt contents, `fill_o` and `frame_o` keep their values.
- R11: After reset, `frame_o`=0, `fill_o`=0, and every read returns NaR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze belt state this cycle |
| drop0_vld_i | input | 1 | Result present on drop port 0 |
| drop0_data_i | input | 32 | Drop port 0 data |
| drop0_nar_i | input | 1 | Drop port 0 NaR flag |
| drop0_width_i | input | 2 | Drop port 0 width code |
| drop0_lanes_i | input | 3 | Drop port 0 lane field |
| drop1_vld_i | input | 1 | Result present on drop port 1 |
| drop1_data_i | input | 32 | Drop port 1 data |
| drop1_nar_i | input | 1 | Drop port 1 NaR flag |
| drop1_width_i | input | 2 | Drop port 1 width code |
| drop1_lanes_i | input | 3 | Drop port 1 lane field |
| call_i | input | 1 | Enter a new frame |
| ret_i | input | 1 | Leave the current frame |
| rd_pos_i | input | 6 | Belt position per read port, 3 bits each |
| rd_data_o | output | 64 | Operand data per read port |
| rd_nar_o | output | 2 | Operand NaR flag per read port |
| rd_width_o | output | 2×2 = 4 | Operand width code per read port |
| rd_lanes_o | output | 6 | Operand lane field per read port |
| fill_o | output | 4 | Items held in the active frame |
| frame_o | output | 2 | Active frame number |

## Verification
The bench keeps a shifting reference belt for each frame and reads every position on both ports after each cycle. It covers dual drops whose port-to-position order could be reversed, wrap of the head pointer past the ring end, and saturation where a wrong count would expose stale slots as valid. Calls and returns are made while results are also being dropped, at the deepest frame, at frame 0, and in the same cycle as each other. A design that dropped into the wrong frame, or failed to clear the callee's fill count, would show foreign items or lose the caller's belt after the return. Stalled cycles that carry drops, a call and a return must leave every read and both status outputs exactly as they were.

// File: rtl/belt_store.sv
module belt_store #(
  parameter int LEN    = 8,
  parameter int DATA_W = 32,
  parameter int FRAMES = 4,
  parameter int READS  = 2,
  parameter int LANE_W = 3,
  localparam int POS_W   = $clog2(LEN),
  localparam int CNT_W   = $clog2(LEN + 1),
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int META_W  = 3 + LANE_W,
  localparam int IDX_W   = FRAME_W + POS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stall_i,
  input  logic                      drop0_vld_i,
  input  logic [DATA_W-1:0]         drop0_data_i,
  input  logic                      drop0_nar_i,
  input  logic [1:0]                drop0_width_i,
  input  logic [LANE_W-1:0]         drop0_lanes_i,
  input  logic                      drop1_vld_i,
  input  logic [DATA_W-1:0]         drop1_data_i,
  input  logic                      drop1_nar_i,
  input  logic [1:0]                drop1_width_i,
  input  logic [LANE_W-1:0]         drop1_lanes_i,
  input  logic                      call_i,
  input  logic                      ret_i,
  input  logic [READS*POS_W-1:0]    rd_pos_i,
  output logic [READS*DATA_W-1:0]   rd_data_o,
  output logic [READS-1:0]          rd_nar_o,
  output logic [READS*2-1:0]        rd_width_o,
  output logic [READS*LANE_W-1:0]   rd_lanes_o,
  output logic [CNT_W-1:0]          fill_o,
  output logic [FRAME_W-1:0]        frame_o
);

  logic [DATA_W-1:0] mem_data [FRAMES*LEN];
  logic [META_W-1:0] mem_meta [FRAMES*LEN];
  logic [POS_W-1:0]  head_q [FRAMES];
  logic [CNT_W-1:0]  fill_q [FRAMES];
  logic [FRAME_W-1:0] frame_q;

  wire go = !stall_i;
  wire w0 = go & drop0_vld_i;
  wire w1 = go & drop1_vld_i;
  wire [1:0] n_drop = {1'b0, w0} + {1'b0, w1};

  wire [POS_W-1:0] hd    = head_q[frame_q];
  wire [POS_W-1:0] hd_p1 = hd + 1'b1;
  wire [IDX_W-1:0] idx_a = {frame_q, hd};
  wire [IDX_W-1:0] idx_b = {frame_q, hd_p1};

  wire [META_W-1:0] meta0 = {drop0_nar_i, drop0_width_i, drop0_lanes_i};
  wire [META_W-1:0] meta1 = {drop1_nar_i, drop1_width_i, drop1_lanes_i};
  wire [DATA_W-1:0] a_data = w1 ? drop1_data_i : drop0_data_i;
  wire [META_W-1:0] a_meta = w1 ? meta1 : meta0;

  wire [CNT_W:0]   fill_sum = {1'b0, fill_q[frame_q]} + (CNT_W+1)'(n_drop);
  wire [CNT_W-1:0] fill_nx  = (fill_sum > (CNT_W+1)'(LEN)) ? CNT_W'(LEN) : fill_sum[CNT_W-1:0];

  wire [FRAME_W-1:0] frame_up = frame_q + 1'b1;
  wire do_call = go & call_i & !ret_i & (frame_q != FRAME_W'(FRAMES - 1));
  wire do_ret  = go & ret_i & !call_i & (frame_q != '0);

  always_ff @(posedge clk) begin
    if (w0 | w1) begin
      mem_data[idx_a] <= a_data;
      mem_meta[idx_a] <= a_meta;
    end
    if (w0 & w1) begin
      mem_data[idx_b] <= drop0_data_i;
      mem_meta[idx_b] <= meta0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < FRAMES; f++) begin
        head_q[f] <= '0;
        fill_q[f] <= '0;
      end
      frame_q <= '0;
    end else begin
      head_q[frame_q] <= hd + POS_W'(n_drop);
      fill_q[frame_q] <= fill_nx;
      if (do_call) begin
        frame_q <= frame_up;
        head_q[frame_up] <= '0;
        fill_q[frame_up] <= '0;
      end
      if (do_ret) frame_q <= frame_q - 1'b1;
    end
  end

  for (genvar r = 0; r < READS; r++) begin : g_rd
    wire [POS_W-1:0]  pos  = rd_pos_i[r*POS_W +: POS_W];
    wire              hit  = CNT_W'(pos) < fill_q[frame_q];
    wire [POS_W-1:0]  slot = hd - 1'b1 - pos;
    wire [IDX_W-1:0]  idx  = {frame_q, slot};
    wire [META_W-1:0] m    = mem_meta[idx];
    assign rd_data_o[r*DATA_W +: DATA_W] = hit ? mem_data[idx] : '0;
    assign rd_nar_o[r]                   = hit ? m[META_W-1] : 1'b1;
    assign rd_width_o[r*2 +: 2]          = hit ? m[LANE_W +: 2] : 2'b00;
    assign rd_lanes_o[r*LANE_W +: LANE_W] = hit ? m[LANE_W-1:0] : '0;
  end

  assign fill_o  = fill_q[frame_q];
  assign frame_o = frame_q;

endmodule

// File: rtl/belt_store_chk.sv
module belt_store_chk #(
  parameter int LEN    = 8,
  parameter int DATA_W = 32,
  parameter int FRAMES = 4,
  parameter int READS  = 2,
  localparam int POS_W   = $clog2(LEN),
  localparam int CNT_W   = $clog2(LEN + 1),
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stall_i,
  input logic                    drop0_vld_i,
  input logic                    drop1_vld_i,
  input logic                    call_i,
  input logic                    ret_i,
  input logic [READS*POS_W-1:0]  rd_pos_i,
  input logic [READS*DATA_W-1:0] rd_data_o,
  input logic [READS-1:0]        rd_nar_o,
  input logic [CNT_W-1:0]        fill_o,
  input logic [FRAME_W-1:0]      frame_o
);

  logic [CNT_W:0] prev_sum;
  always_ff @(posedge clk)
    prev_sum <= {1'b0, fill_o} + (CNT_W+1)'(drop0_vld_i) + (CNT_W+1)'(drop1_vld_i);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= CNT_W'(LEN));

  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !call_i && !ret_i) |=>
      (fill_o == ((prev_sum > (CNT_W+1)'(LEN)) ? CNT_W'(LEN) : prev_sum[CNT_W-1:0])));

  // R6
  call_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !stall_i && frame_o != FRAME_W'(FRAMES - 1)) |=>
      (frame_o == FRAME_W'($past(frame_o) + 1'b1) && fill_o == '0));

  // R6
  call_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && frame_o == FRAME_W'(FRAMES - 1)) |=> $stable(frame_o));

  // R7
  ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !stall_i && frame_o != '0) |=>
      (frame_o == FRAME_W'($past(frame_o) - 1'b1)));

  // R7
  ret_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && frame_o == '0) |=> $stable(frame_o));

  // R8
  call_ret_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(frame_o));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(frame_o) && $stable(fill_o)));

  for (genvar r = 0; r < READS; r++) begin : g_miss
    // R4
    miss_nar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(rd_pos_i[r*POS_W +: POS_W]) >= fill_o) |->
        (rd_nar_o[r] && rd_data_o[r*DATA_W +: DATA_W] == '0));
  end

endmodule

bind belt_store belt_store_chk #(
  .LEN(LEN), .DATA_W(DATA_W), .FRAMES(FRAMES), .READS(READS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
  .drop0_vld_i(drop0_vld_i), .drop1_vld_i(drop1_vld_i),
  .call_i(call_i), .ret_i(ret_i), .rd_pos_i(rd_pos_i),
  .rd_data_o(rd_data_o), .rd_nar_o(rd_nar_o),
  .fill_o(fill_o), .frame_o(frame_o)
);

// File: tb/belt_store_tb_top.sv
module belt_store_tb_top;
  localparam int LEN = 8, DATA_W = 32, FRAMES = 4, READS = 2, LANE_W = 3;
  localparam int POS_W = 3, CNT_W = 4, FRAME_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, stall_i = 1'b0;
  logic drop0_vld_i = 1'b0, drop1_vld_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [DATA_W-1:0] drop0_data_i = '0, drop1_data_i = '0;
  logic drop0_nar_i = 1'b0, drop1_nar_i = 1'b0;
  logic [1:0] drop0_width_i = '0, drop1_width_i = '0;
  logic [LANE_W-1:0] drop0_lanes_i = '0, drop1_lanes_i = '0;
  logic [READS*POS_W-1:0] rd_pos_i = '0;
  logic [READS*DATA_W-1:0] rd_data_o;
  logic [READS-1:0] rd_nar_o;
  logic [READS*2-1:0] rd_width_o;
  logic [READS*LANE_W-1:0] rd_lanes_o;
  logic [CNT_W-1:0] fill_o;
  logic [FRAME_W-1:0] frame_o;

  always #10 clk = ~clk;

  belt_store dut_i (.*);

  int checks = 0, failures = 0, k = 0;
  logic [DATA_W-1:0] m_data [FRAMES][LEN];
  logic [5:0]        m_meta [FRAMES][LEN];
  int                m_fill [FRAMES];
  int                m_frame = 0;

  function automatic void push(logic [DATA_W-1:0] d, logic [5:0] m);
    for (int p = LEN - 1; p > 0; p--) begin
      m_data[m_frame][p] = m_data[m_frame][p-1];
      m_meta[m_frame][p] = m_meta[m_frame][p-1];
    end
    m_data[m_frame][0] = d;
    m_meta[m_frame][0] = m;
    if (m_fill[m_frame] < LEN) m_fill[m_frame]++;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk(frame_o == FRAME_W'(m_frame), tag, "frame", 64'(frame_o), 64'(m_frame));
    chk(fill_o == CNT_W'(m_fill[m_frame]), tag, "fill", 64'(fill_o), 64'(m_fill[m_frame]));
    for (int p = 0; p < LEN; p++) begin
      rd_pos_i = {POS_W'(LEN - 1 - p), POS_W'(p)};
      #1;
      for (int r = 0; r < READS; r++) begin
        int pos;
        logic [DATA_W+5:0] act, exp;
        pos = (r == 0) ? p : LEN - 1 - p;
        act = {rd_data_o[r*DATA_W +: DATA_W], rd_nar_o[r], rd_width_o[r*2 +: 2],
               rd_lanes_o[r*LANE_W +: LANE_W]};
        if (pos < m_fill[m_frame]) exp = {m_data[m_frame][pos], m_meta[m_frame][pos]};
        else exp = {{DATA_W{1'b0}}, 6'b100000};
        chk(act == exp, tag, $sformatf("read pos %0d", pos), 64'(act), 64'(exp));
      end
    end
  endtask

  task automatic step(bit d0, bit d1, bit c, bit r, bit s, string tag);
    logic [DATA_W-1:0] v0, v1;
    logic [5:0] mt0, mt1;
    v0  = 32'h1000_0000 + 32'(k * 3);
    v1  = 32'h2000_0000 + 32'(k * 5);
    mt0 = {(k % 5) == 0, 2'(k), 3'(k)};
    mt1 = {(k % 3) == 0, ~2'(k), 3'(k >> 2)};
    drop0_vld_i = d0; drop1_vld_i = d1; call_i = c; ret_i = r; stall_i = s;
    drop0_data_i = v0; {drop0_nar_i, drop0_width_i, drop0_lanes_i} = mt0;
    drop1_data_i = v1; {drop1_nar_i, drop1_width_i, drop1_lanes_i} = mt1;
    @(posedge clk);
    #2;
    if (!s) begin
      if (d1) push(v1, mt1);
      if (d0) push(v0, mt0);
      if (c && !r && m_frame < FRAMES - 1) begin
        m_frame++;
        m_fill[m_frame] = 0;
      end
      if (r && !c && m_frame > 0) m_frame--;
    end
    drop0_vld_i = 0; drop1_vld_i = 0; call_i = 0; ret_i = 0; stall_i = 0;
    k++;
    check_state(tag);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int f = 0; f < FRAMES; f++) m_fill[f] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_state("R11");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R1 R5");
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, "R1 R5");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, "R3");
    step(1, 1, 1, 0, 1, "R10");
    step(1, 1, 0, 1, 1, "R10");
    step(1, 1, 1, 0, 0, "R9 R6");
    for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, "R4 R5");
    step(0, 0, 1, 0, 0, "R6");
    step(1, 0, 1, 0, 0, "R6 R9");
    step(0, 0, 1, 0, 0, "R6");
    step(0, 0, 1, 1, 0, "R8");
    step(1, 1, 0, 1, 0, "R7 R9");
    step(0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 600; i++) begin
      bit d0, d1, c, r, s;
      d0 = ((i * 7) % 4) & 1;
      d1 = ((i * 7) % 4) >> 1;
      c  = (i % 11) == 3;
      r  = (i % 13) == 5 || (i % 29) == 8;
      s  = (i % 17) == 9;
      step(d0, d1, c, r, s, "R1 R2 R3 R6 R7 R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule